// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block provides twelve general-purpose pins behind a plain 32-bit word-addressed register bus. Each pin can be an input or an output. An output is driven from a stored data bit. An input is brought into the clock domain by a two-stage synchronizer and can then be read back. Register reads are combinational from the presented address, and writes take effect on the rising clock edge that samples a request with write enable set.

Every pin has its own trigger detector. It can be programmed for rising edge, falling edge, either edge, high level or low level. Detected events on enabled pins are latched as pending status. Software masks and unmasks pins through separate set and clear registers, and acknowledges pending bits by writing ones. A single request line to the host is high while any pending pin is unmasked. A soft-reset register holds the whole block at its defaults while its bit 0 is 1. Releasing that bit leaves the block in the defaults.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe_o = 0), output data is 0, enables, masks and trigger modes are all 0, no status bit is pending, and irq_o is low.
- R2: pin_oe_o and pin_o follow the direction and output-data registers bit for bit, with 1 meaning output. Only bits 11:0 are stored, and bits 31:12 read as 0.
- R3: The input-data register shows the pin levels after a two-flop synchronizer, so a change is visible on the second clock edge after it. Writes to that register have no effect.
- R4: Word offsets (byte address): 0x00 enable, 0x04 status, 0x08 display, 0x0C clear, 0x10 mask set, 0x14 mask clear, 0x18 output data, 0x1C input data, 0x20 direction, 0x24 mode 0, 0x28 mode 1, 0x38 use-select, 0x3C soft reset. Mask set and mask clear both read back the mask. The clear register and unlisted offsets read 0. An access with address bits 1:0 not zero is ignored and reads 0.
- R5: Pin n has a 3-bit mode field at bits 4n+2:4n of mode 0 for n < 8, and at bits 4(n-8)+2:4(n-8) of mode 1 for n >= 8. Bit 3 of each nibble reads 0. Codes are 0 falling, 1 rising, 2 low level, 3 high level and 4 both edges. Codes 5 to 7 never detect.
- R6: An edge event sets the pin's status bit on the third clock edge after the pin changes, but only while the pin's enable bit is 1. With enable 0 the status bit is not set.
- R7: In a level mode the status bit is set again on the clock after a clear, for as long as the level persists on an enabled pin.
- R8: Writing 1 to a bit of the clear register clears that status bit, and 0 bits have no effect. If a new event arrives in the same cycle as the clear, the event wins and the bit stays set.
- R9: Writing 1s to mask set masks pins, writing 1s to mask clear unmasks them, and 0 bits leave the mask unchanged. The display register reads status AND NOT mask, and irq_o is the OR of the display bits. Writes to status and display have no effect.
- R10: Writing 1 to bit 0 of the soft-reset register holds all registers and status at their reset values, and other writes are ignored. Writing 0 afterwards releases the block in the reset state. Bit 0 reads back the held value.
- R11: The use-select register stores bits 11:0 of the written data and reads them back, and it has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | Write enable (with bus_req_i) |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pin_i | input | 12 | Pin levels from the pads |
| pin_o | output | 12 | Output-data drive values |
| pin_oe_o | output | 12 | Output enables (1 = drive) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The two functions that can fall in the same cycle are a software clear of a pending bit and a fresh detection on that pin. The bench changes a pin configured for rising edges and then times a clear write so that it lands on the exact edge where the synchronized edge registers. It then expects the status bit to remain set, and a later clear on its own must remove it. Level-mode pins exercise the same collision continuously, because the bit must reappear one cycle after every clear while the level holds.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int unsigned BUS_W         = 32;
  localparam int unsigned ADDR_W        = 6;
  localparam int unsigned MODE_W        = 3;
  localparam int unsigned FIELD_SP      = 4;
  localparam int unsigned PINS_PER_MODE = BUS_W / FIELD_SP;
  localparam int unsigned MODE_REGS     = 2;

  localparam logic [2:0] TRIG_FALL = 3'd0;
  localparam logic [2:0] TRIG_RISE = 3'd1;
  localparam logic [2:0] TRIG_LOW  = 3'd2;
  localparam logic [2:0] TRIG_HIGH = 3'd3;
  localparam logic [2:0] TRIG_BOTH = 3'd4;

  // word index = byte address [5:2]
  localparam logic [3:0] REG_IEN    = 4'd0;
  localparam logic [3:0] REG_ISTAT  = 4'd1;
  localparam logic [3:0] REG_IDISP  = 4'd2;
  localparam logic [3:0] REG_ICLR   = 4'd3;
  localparam logic [3:0] REG_MSET   = 4'd4;
  localparam logic [3:0] REG_MCLR   = 4'd5;
  localparam logic [3:0] REG_DOUT   = 4'd6;
  localparam logic [3:0] REG_DIN    = 4'd7;
  localparam logic [3:0] REG_DIR    = 4'd8;
  localparam logic [3:0] REG_MODE0  = 4'd9;
  localparam logic [3:0] REG_MODE1  = 4'd10;
  localparam logic [3:0] REG_USESEL = 4'd14;
  localparam logic [3:0] REG_SRST   = 4'd15;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_pin_det.sv
`timescale 1ns/1ps
module gpio_pin_det
  import gpio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              lvl_i,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wd_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              stat_o
);
  logic              prev_q;
  logic              stat_q;
  logic [MODE_W-1:0] mode_q;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= TRIG_FALL;
    else if (srst_i)    mode_q <= TRIG_FALL;
    else if (mode_we_i) mode_q <= mode_wd_i;
  end

  always_comb begin
    case (mode_q)
      TRIG_FALL: hit = prev_q & ~lvl_i;
      TRIG_RISE: hit = ~prev_q & lvl_i;
      TRIG_LOW:  hit = ~lvl_i;
      TRIG_HIGH: hit = lvl_i;
      TRIG_BOTH: hit = prev_q ^ lvl_i;
      default:   hit = 1'b0;
    endcase
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= 1'b0;
    else if (srst_i) stat_q <= 1'b0;
    else             stat_q <= (stat_q & ~clr_i) | (hit & en_i);
  end

  assign mode_o = mode_q;
  assign stat_o = stat_q;

  a_r6_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(en_i));

  a_r7_level_refire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && en_i && mode_q == TRIG_HIGH && lvl_i) |=> stat_q);

  a_r5_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !mode_we_i && mode_q > TRIG_BOTH && !stat_q) |=> !stat_q);

  a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && en_i && hit && clr_i) |=> stat_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BUS_W-1:0]    bus_wdata_i,
  output logic [BUS_W-1:0]    bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned PAD_W = BUS_W - NUM_PINS;

  logic [3:0]          widx;
  logic                acc_ok;
  logic                wr_en;
  logic                srst_q;
  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] en_q, mask_q, dout_q, dir_q, use_q;
  logic [NUM_PINS-1:0] din_s, stat_v, disp_v, clr_v;
  logic [MODE_W-1:0]   mode_v [NUM_PINS];
  logic [BUS_W-1:0]    mode_rd [MODE_REGS];

  assign widx   = bus_addr_i[5:2];
  assign acc_ok = (bus_addr_i[1:0] == 2'b00);
  assign wr_en  = bus_req_i & bus_we_i & acc_ok & ~srst_q;
  assign wd     = bus_wdata_i[NUM_PINS-1:0];
  assign clr_v  = (wr_en && widx == REG_ICLR) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else if (bus_req_i && bus_we_i && acc_ok && widx == REG_SRST)
      srst_q <= bus_wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      use_q  <= '0;
    end else if (srst_q) begin
      en_q   <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
      use_q  <= '0;
    end else if (wr_en) begin
      case (widx)
        REG_IEN:    en_q   <= wd;
        REG_MSET:   mask_q <= mask_q | wd;
        REG_MCLR:   mask_q <= mask_q & ~wd;
        REG_DOUT:   dout_q <= wd;
        REG_DIR:    dir_q  <= wd;
        REG_USESEL: use_q  <= wd;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (din_s)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [3:0]  MADR = REG_MODE0 + 4'(p / PINS_PER_MODE);
    localparam int unsigned POS  = (p % PINS_PER_MODE) * FIELD_SP;
    gpio_pin_det u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .srst_i    (srst_q),
      .lvl_i     (din_s[p]),
      .en_i      (en_q[p]),
      .clr_i     (clr_v[p]),
      .mode_we_i (wr_en && widx == MADR),
      .mode_wd_i (bus_wdata_i[POS +: MODE_W]),
      .mode_o    (mode_v[p]),
      .stat_o    (stat_v[p])
    );
  end

  always_comb begin
    for (int r = 0; r < MODE_REGS; r++) mode_rd[r] = '0;
    for (int p = 0; p < NUM_PINS; p++)
      mode_rd[p / PINS_PER_MODE][(p % PINS_PER_MODE) * FIELD_SP +: MODE_W] = mode_v[p];
  end

  assign disp_v = stat_v & ~mask_q;

  always_comb begin
    bus_rdata_o = '0;
    if (acc_ok) begin
      case (widx)
        REG_IEN:    bus_rdata_o = {{PAD_W{1'b0}}, en_q};
        REG_ISTAT:  bus_rdata_o = {{PAD_W{1'b0}}, stat_v};
        REG_IDISP:  bus_rdata_o = {{PAD_W{1'b0}}, disp_v};
        REG_MSET,
        REG_MCLR:   bus_rdata_o = {{PAD_W{1'b0}}, mask_q};
        REG_DOUT:   bus_rdata_o = {{PAD_W{1'b0}}, dout_q};
        REG_DIN:    bus_rdata_o = {{PAD_W{1'b0}}, din_s};
        REG_DIR:    bus_rdata_o = {{PAD_W{1'b0}}, dir_q};
        REG_MODE0:  bus_rdata_o = mode_rd[0];
        REG_MODE1:  bus_rdata_o = mode_rd[1];
        REG_USESEL: bus_rdata_o = {{PAD_W{1'b0}}, use_q};
        REG_SRST:   bus_rdata_o = {{(BUS_W-1){1'b0}}, srst_q};
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  assign pin_o    = dout_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |disp_v;

  a_r10_soft_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (pin_oe_o == '0 && pin_o == '0 && !irq_o));

  a_r9_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && widx == REG_MSET) |=> ((mask_q & $past(wd)) == $past(wd)));

  a_r9_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && widx == REG_MCLR) |=> ((mask_q & $past(wd)) == '0));

  a_r9_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_v != '0));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int NP = 12;
  localparam logic [5:0] A_IEN = 6'h00, A_ISTAT = 6'h04, A_IDISP = 6'h08, A_ICLR = 6'h0C,
                         A_MSET = 6'h10, A_MCLR = 6'h14, A_DOUT = 6'h18, A_DIN = 6'h1C,
                         A_DIR = 6'h20, A_MODE0 = 6'h24, A_MODE1 = 6'h28, A_USE = 6'h38,
                         A_SRST = 6'h3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_o, pin_oe;
  logic irq;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdat), .bus_rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [NP-1:0] m_en = '0, m_mask = '0, m_stat = '0;
  logic [2:0] m_mode [NP];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdat = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic hit(logic [2:0] m, logic o, logic n);
    case (m)
      3'd0: return o & ~n;
      3'd1: return ~o & n;
      3'd2: return ~n;
      3'd3: return n;
      3'd4: return o ^ n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic apply_levels();
    for (int p = 0; p < NP; p++)
      if (m_en[p] && hit(m_mode[p], pins[p], pins[p])) m_stat[p] = 1'b1;
  endtask

  task automatic set_pins(logic [NP-1:0] nv);
    logic [NP-1:0] ov;
    ov = pins;
    @(negedge clk);
    pins = nv;
    for (int p = 0; p < NP; p++)
      if (m_en[p] && hit(m_mode[p], ov[p], nv[p])) m_stat[p] = 1'b1;
    settle();
    apply_levels();
  endtask

  task automatic check_irq(string tag);
    logic [31:0] v;
    rd(A_ISTAT, v);
    chk({tag, " status"}, v, 32'(m_stat));
    rd(A_IDISP, v);
    chk({tag, " display"}, v, 32'(m_stat & ~m_mask));
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, |(m_stat & ~m_mask)});
  endtask

  task automatic write_mode(logic [5:0] a, logic [31:0] d);
    wr(a, d);
    for (int p = 0; p < NP; p++)
      if ((p < 8) == (a == A_MODE0)) m_mode[p] = d[(p % 8) * 4 +: 3];
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int p = 0; p < NP; p++) m_mode[p] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_DIR, v);   chk("R1 dir", v, 0);
    rd(A_DOUT, v);  chk("R1 dout", v, 0);
    rd(A_IEN, v);   chk("R1 enable", v, 0);
    rd(A_MSET, v);  chk("R1 mask", v, 0);
    rd(A_MODE0, v); chk("R1 mode0", v, 0);
    rd(A_MODE1, v); chk("R1 mode1", v, 0);
    chk("R1 oe", 32'(pin_oe), 0);
    check_irq("R1");

    // R2 direction and output data
    wr(A_DIR, 32'hFFFF_F0A5);
    rd(A_DIR, v); chk("R2 dir readback", v, 32'h0A5);
    chk("R2 oe", 32'(pin_oe), 32'h0A5);
    wr(A_DOUT, 32'h8000_05A3);
    chk("R2 pin_o", 32'(pin_o), 32'h5A3);

    // R4 offsets and alignment
    wr(A_USE, 32'h0000_0123);
    rd(A_DOUT, v); chk("R4 dout", v, 32'h5A3);
    rd(A_USE, v);  chk("R4 use", v, 32'h123);
    rd(6'h19, v);  chk("R4 misaligned read", v, 0);
    wr(6'h21, 32'h0);
    rd(A_DIR, v);  chk("R4 misaligned write", v, 32'h0A5);
    rd(A_ICLR, v); chk("R4 clear reads 0", v, 0);
    // R11 use-select storage
    wr(A_USE, 32'hFFFF_FFFF);
    rd(A_USE, v);  chk("R11 use width", v, 32'hFFF);

    // R3 synchronizer latency and write ignore
    @(negedge clk);
    pins = 12'hABC;
    @(negedge clk);
    rd(A_DIN, v); chk("R3 din after 1 edge", v, 0);
    @(negedge clk);
    rd(A_DIN, v); chk("R3 din after 2 edges", v, 32'hABC);
    wr(A_DIN, 32'h0000_0543);
    rd(A_DIN, v); chk("R3 din write ignored", v, 32'hABC);
    settle();

    // R5 field layout
    write_mode(A_MODE0, 32'hFFFF_FFFF);
    rd(A_MODE0, v); chk("R5 mode0 nibbles", v, 32'h7777_7777);
    write_mode(A_MODE1, 32'h0000_0010);
    rd(A_MODE1, v); chk("R5 mode1 pin9", v, 32'h10);
    // R5 codes 5..7 never detect (mode0 pins all 7)
    m_en = 12'h0FF; wr(A_IEN, 32'hFF);
    set_pins(12'h000); set_pins(12'h0FF); set_pins(12'h000);
    check_irq("R5 idle codes");

    // R6 rising edge on pin 9, enable gate on pin 8 (mode 0 falling)
    write_mode(A_MODE0, 32'h0);
    m_en = 12'h200; wr(A_IEN, 32'h200);
    settle(); apply_levels();
    set_pins(12'h300);
    check_irq("R6 rise enabled");
    set_pins(12'h200);
    check_irq("R6 fall disabled");
    chk("R6 pin9 set", 32'(m_stat[9]), 1);

    // R8 clear
    m_stat[9] = 1'b0; wr(A_ICLR, 32'h200);
    check_irq("R8 clear");
    // R8 same-cycle collision: edge registers on 3rd edge, clear lands there
    set_pins(12'h000);
    @(negedge clk);
    pins = 12'h200;
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = A_ICLR; wdat = 32'h200;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(A_ISTAT, v); chk("R8 event wins", v & 32'h200, 32'h200);
    m_stat[9] = 1'b1;
    settle();
    m_stat[9] = 1'b0; wr(A_ICLR, 32'h200);
    check_irq("R8 clear after collision");

    // R7 high-level on pin 2 refires after clear
    write_mode(A_MODE0, 32'h0000_0300);
    m_en = 12'h004; wr(A_IEN, 32'h004);
    set_pins(12'h004);
    check_irq("R7 level set");
    m_stat[2] = 1'b0; wr(A_ICLR, 32'h004);
    settle(); apply_levels();
    check_irq("R7 refire");
    set_pins(12'h000);
    m_stat[2] = 1'b0; wr(A_ICLR, 32'h004);
    settle(); apply_levels();
    check_irq("R7 clears when low");

    // R9 mask behaviour and status/display write ignore
    set_pins(12'h004);
    m_mask = 12'h014; wr(A_MSET, 32'h014);
    check_irq("R9 masked");
    m_mask = 12'h010; wr(A_MCLR, 32'h004);
    check_irq("R9 unmasked");
    wr(A_ISTAT, 32'h0); wr(A_IDISP, 32'h0);
    check_irq("R9 status write ignored");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      int op;
      d = $urandom;
      op = $urandom_range(0, 5);
      case (op)
        0: begin m_en = d[NP-1:0]; wr(A_IEN, d); end
        1: begin m_mask = m_mask | d[NP-1:0]; wr(A_MSET, d); end
        2: begin m_mask = m_mask & ~d[NP-1:0]; wr(A_MCLR, d); end
        3: begin m_stat = m_stat & ~d[NP-1:0]; wr(A_ICLR, d); end
        4: write_mode(($urandom_range(0, 1) == 0) ? A_MODE0 : A_MODE1, d);
        default: set_pins(d[NP-1:0]);
      endcase
      settle();
      apply_levels();
      check_irq("R6 R9 random");
    end

    // R10 soft reset
    wr(A_DIR, 32'hFFF); wr(A_MSET, 32'h0F0); wr(A_IEN, 32'hFFF);
    wr(A_SRST, 32'h1);
    rd(A_SRST, v); chk("R10 srst readback", v, 1);
    wr(A_DIR, 32'hFFF);
    rd(A_DIR, v); chk("R10 write ignored while held", v, 0);
    chk("R10 irq held low", {31'b0, irq}, 0);
    wr(A_SRST, 32'h0);
    rd(A_SRST, v);  chk("R10 srst released", v, 0);
    rd(A_DIR, v);   chk("R10 dir", v, 0);
    rd(A_IEN, v);   chk("R10 enable", v, 0);
    rd(A_MSET, v);  chk("R10 mask", v, 0);
    rd(A_MODE0, v); chk("R10 mode0", v, 0);
    rd(A_USE, v);   chk("R10 use", v, 0);
    rd(A_ISTAT, v); chk("R10 status", v, 0);
    chk("R10 oe", 32'(pin_oe), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule